// File: doc/BRIEF.md
# Register Security and Privilege Filter

This block guards a small peripheral register file that is split into six protectable feature groups: supply configuration, voltage scaling, low-power mode, wake-up pins, voltage monitoring and battery mode. Every bus access carries a secure flag and a privileged flag. The block holds one security bit and one privilege bit per group and checks each access against the bits of the group it targets.

A refused access does not raise a bus error. Its read returns zero, its write is dropped, and the block pulses an illegal-access line toward an external access controller. Two further registers hold the security and privilege bits. They are reached through the same port and follow their own rules on who may change them.

Each group holds one data word at addresses 0 to NGRP-1. The security register sits at address NGRP and the privilege register at NGRP+1. Bit g of either attribute register belongs to group g. A request is taken in the cycle where `req_i` is high. Its response appears one cycle later.

Top module: `reg_attr_filter`

## Requirements
- R1: After reset, both attribute registers and all group words are zero, so every group access is permitted.
- R2: A non-secure access (`sec_i`=0) to a group whose security bit is 1 reads zero and leaves the group word unchanged.
- R3: An unprivileged access (`priv_i`=0) to a group whose privilege bit is 1 reads zero and leaves the group word unchanged.
- R4: Every request is acknowledged by `ack_o` high for one cycle in the following cycle, whether or not it was refused. No error is ever signalled.
- R5: A refused access raises `illegal_o` for exactly one cycle, together with its acknowledge. An access that breaks both the security and the privilege rule gives a single pulse.
- R6: A secure write to the security register (address NGRP) replaces all group security bits, whatever its privilege. A non-secure write to it is ignored and pulses `illegal_o`.
- R7: An unprivileged write to the privilege register (address NGRP+1) is ignored and pulses `illegal_o`.
- R8: A secure privileged write to the privilege register replaces all bits. A non-secure privileged write updates only the bits of non-secure groups. It pulses `illegal_o` when it tries to change a bit of a secure group.
- R9: A secure read of an attribute register returns its value. A non-secure read returns it with the bits of secure groups forced to zero. Attribute reads never pulse `illegal_o`.
- R10: A permitted group read returns the last permitted write to that group, and `rdata_o` is zero-extended above the attribute bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address: groups, then the security register, then the privilege register |
| wdata_i | input | DW | Write data |
| sec_i | input | 1 | Access is secure |
| priv_i | input | 1 | Access is privileged |
| ack_o | output | 1 | Response, one cycle after the request |
| illegal_o | output | 1 | One-cycle illegal-access pulse, aligned with `ack_o` |
| rdata_o | output | DW | Read data, valid with `ack_o` |

## Verification
A wrong security or privilege bit shows up at the very next access to that group. That access gives a zero read where data was expected, or data where zero was expected, and `illegal_o` disagrees with the rule in the same response cycle. A wrong attribute bit also shows up on the next secure read of the attribute registers. A dropped or leaked group write is seen on the next permitted read of that group.

The sweep walks every security pattern against a set of privilege patterns. Under each pair it tries all four secure/privileged combinations on every group and on both attribute registers. A state error therefore surfaces within a few accesses of the point where it arises.

// File: rtl/reg_attr_filter.sv
`timescale 1ns/1ps
module reg_attr_filter #(
  parameter int NGRP = 6,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NGRP + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sec_i,
  input  logic          priv_i,
  output logic          ack_o,
  output logic          illegal_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] SEC_A  = AW'(NGRP);
  localparam logic [AW-1:0] PRIV_A = AW'(NGRP + 1);

  logic [NGRP-1:0]         sec_q, priv_q;
  logic [NGRP-1:0][DW-1:0] grp_q;
  logic [DW-1:0]           rd;
  logic                    wr_q;

  wire             grp_hit = addr_i < SEC_A;
  wire [NGRP-1:0]  sel     = grp_hit ? (NGRP'(1) << addr_i) : '0;
  wire             deny    = |(sel & ((sec_q & {NGRP{~sec_i}}) | (priv_q & {NGRP{~priv_i}})));
  wire [NGRP-1:0]  wmask   = wdata_i[NGRP-1:0];
  wire [NGRP-1:0]  lock    = sec_i ? '0 : sec_q;
  wire             sec_wr  = req_i & we_i & (addr_i == SEC_A);
  wire             priv_wr = req_i & we_i & (addr_i == PRIV_A);
  wire             priv_bad = ~priv_i | (|((wmask ^ priv_q) & lock));
  wire             viol    = req_i & (deny | (sec_wr & ~sec_i) | (priv_wr & priv_bad));

  always_comb begin
    rd = '0;
    if (grp_hit && !deny) begin
      for (int g = 0; g < NGRP; g++)
        if (sel[g]) rd = grp_q[g];
    end else if (addr_i == SEC_A) begin
      rd = DW'(sec_i ? sec_q : '0);
    end else if (addr_i == PRIV_A) begin
      rd = DW'(priv_q & ~lock);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q     <= '0;
      priv_q    <= '0;
      grp_q     <= '0;
      ack_o     <= 1'b0;
      illegal_o <= 1'b0;
      rdata_o   <= '0;
      wr_q      <= 1'b0;
    end else begin
      ack_o     <= req_i;
      illegal_o <= viol;
      wr_q      <= req_i & we_i;
      if (req_i && !we_i) rdata_o <= rd;
      if (sec_wr && sec_i) sec_q <= wmask;
      if (priv_wr && priv_i) priv_q <= (priv_q & lock) | (wmask & ~lock);
      if (req_i && we_i && !deny)
        for (int g = 0; g < NGRP; g++)
          if (sel[g]) grp_q[g] <= wdata_i;
    end
  end

  a_r1_reset_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (sec_q == '0 && priv_q == '0));
  a_r2_denied_write_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && deny) |=> $stable(grp_q));
  a_r3_denied_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && illegal_o && !wr_q) |-> rdata_o == '0);
  a_r5_pulse_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ack_o);
  a_r6_nonsec_sec_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_wr && !sec_i) |=> $stable(sec_q));
  a_r7_unpriv_priv_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_wr && !priv_i) |=> $stable(priv_q));
  a_r8_secure_bits_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_wr && !sec_i) |=> ((priv_q & sec_q) == ($past(priv_q) & sec_q)));
endmodule

// File: tb/reg_attr_filter_test.sv
`timescale 1ns/1ps
module reg_attr_filter_test;
  localparam int NG = 6;
  logic clk = 0, rst_ni = 0, req = 0, we = 0, sec = 0, priv = 0;
  logic [2:0] addr = 0;
  logic [7:0] wd = 0;
  logic ack, ill;
  logic [7:0] rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [5:0] ms = 0, mp = 0;
  logic [7:0] mg [NG];

  always #5 clk = ~clk;

  reg_attr_filter #(.NGRP(NG), .DW(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wd), .sec_i(sec), .priv_i(priv), .ack_o(ack), .illegal_o(ill), .rdata_o(rdata));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input int a, input logic [7:0] d, input bit s, input bit p);
    bit exp_ill = 0;
    logic [7:0] exp_rd = 0;
    string tag = "R10";
    if (a < NG) begin
      bit ds = ms[a] && !s, dp = mp[a] && !p;
      tag = ds ? "R2" : (dp ? "R3" : "R10");
      exp_ill = ds || dp;
      exp_rd = exp_ill ? 8'h00 : mg[a];
      if (w && !exp_ill) mg[a] = d;
    end else if (a == NG) begin
      tag = w ? "R6" : "R9";
      if (w) begin
        exp_ill = !s;
        if (s) ms = d[5:0];
      end else exp_rd = s ? {2'b0, ms} : 8'h00;
    end else begin
      tag = w ? (p ? "R8" : "R7") : "R9";
      if (w) begin
        if (!p) exp_ill = 1;
        else if (s) mp = d[5:0];
        else begin
          exp_ill = ((d[5:0] ^ mp) & ms) != 0;
          mp = (mp & ms) | (d[5:0] & ~ms);
        end
      end else exp_rd = s ? {2'b0, mp} : {2'b0, mp & ~ms};
    end
    @(negedge clk);
    req = 1; we = w; addr = 3'(a); wd = d; sec = s; priv = p;
    @(negedge clk);
    req = 0; we = 0;
    chk("R4 ack", ack, 1);
    chk(exp_ill ? {tag, " R5 illegal"} : {tag, " illegal"}, ill, exp_ill);
    if (!w) chk({tag, " rdata"}, rdata, exp_rd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [5:0] plist [8];
    for (int g = 0; g < NG; g++) mg[g] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 ack idle", ack, 0);
    chk("R1 illegal idle", ill, 0);
    for (int a = 0; a < NG + 2; a++) acc(0, a, 0, 0, 0);
    for (int g = 0; g < NG; g++) acc(1, g, 8'(8'h30 + g), 0, 0);
    for (int g = 0; g < NG; g++) acc(0, g, 0, 0, 0);

    for (int s = 0; s < 64; s++) begin
      plist[0] = 0; plist[1] = 6'h3f; plist[2] = 6'(s); plist[3] = ~6'(s);
      plist[4] = 6'h15; plist[5] = 6'h2a; plist[6] = 6'(s * 5 + 3); plist[7] = 6'(s ^ 6'h0f);
      for (int pi = 0; pi < 8; pi++) begin
        acc(1, NG, 8'(s), 1, pi[0]);
        acc(1, NG + 1, {2'b11, plist[pi]}, 1, 1);
        for (int g = 0; g < NG; g++)
          for (int k = 0; k < 4; k++) begin
            acc(1, g, 8'(s * 7 + pi * 13 + g * 29 + k * 3 + 1), k[1], k[0]);
            acc(0, g, 0, k[1], k[0]);
          end
        for (int k = 0; k < 4; k++) begin
          acc(0, NG, 0, k[1], k[0]);
          acc(0, NG + 1, 0, k[1], k[0]);
        end
        acc(1, NG, 8'(~s), 0, 1);
        acc(1, NG + 1, 8'(s + pi), 0, 1);
        acc(1, NG + 1, 8'(~pi), pi[1], 0);
        acc(0, NG + 1, 0, 1, 1);
      end
    end
    @(negedge clk);
    chk("R5 pulse ends", ill, 0);
    chk("R4 ack ends", ack, 0);
    finish_run();
  end
endmodule